// File: doc/BRIEF.md
# MDIO Management Master for Clause 22 and Clause 45 Frames

This block drives the two-wire management bus of Ethernet PHYs. A host writes one 32-bit command word. The word holds a go flag, a start code, an operation code, a PHY address, a register or device field and a 16-bit payload. When the go flag is set, the block sends one management frame on MDC and MDIO. For a read it captures the 16 bits that the PHY returns. When the frame ends, it drops the go flag, which the host sees as busy.

The start and operation codes go onto the wire exactly as written. The same engine therefore sends short-form (Clause 22) reads and writes as well as long-form (Clause 45) address, write and read frames. A long-form access takes two commands from the host. First comes an address frame that carries the 16-bit register number in its payload, with the device number in the register field. Then, once busy has cleared, the host issues a read or write frame to the same PHY and device.

MDC is made from the system clock by a parameterized divider, and it stays low between frames. When no frame is running, MDIO is released.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the command register reads zero, `mdc` is low and `mdio_oe` is low.
- R2: The command word fields are as follows. Bit 31 is go/busy. Bits 29:25 are the register or device field. Bits 24:20 are the PHY address. Bits 19:18 are the operation code. Bits 17:16 are the start code. Bits 15:0 are the payload.
- R3: Each frame is 64 MDC cycles long and is sent most significant bit first. It consists of 32 ones, then the start code, the operation code, the PHY address, the register/device field, two turnaround bits and 16 payload bits.
- R4: The start code is sent unchanged: 01 selects short-form framing and 00 selects long-form framing.
- R5: Operation code 0 is a long-form address frame and 1 is a write. For both, the block drives the turnaround as 1 then 0, followed by the payload.
- R6: Operation codes 2 (short-form read) and 3 (long-form read) release MDIO from the first turnaround bit to the end of the frame. MDIO is sampled at each rising MDC edge during the 16 data bits.
- R7: When a frame completes, bit 31 clears. After a read, the 16 captured bits replace bits 15:0. After any other operation, the rest of the word is left unchanged.
- R8: A command written while bit 31 is set is ignored. The running frame and the stored word are not affected.
- R9: A command written with bit 31 clear while idle is stored in the register, but no frame starts.
- R10: One MDC period is 2 × `MDC_HALF_DIV` system clocks. MDC is low and MDIO is released whenever the block is not busy.
- R11: MDIO output changes only on falling MDC edges, so it is stable across each rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Current command register (bit 31 = busy) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The main function is exercised with short-form writes and reads and with long-form address, write and read frames. Several PHY addresses and register/device values are used, so a swapped or misplaced field shows up on the wire. Read responses include an all-ones-edge pattern, a lone MSB and alternating nibbles. These catch capture shifted by one bit and off-by-one sampling windows. The write payloads check the turnaround pattern and the direction of release. The two-step long-form sequence shows that each frame carries its own start and operation codes.

// File: rtl/mdio_pkg.sv
// Package: shared command-word layout and frame constants for the MDIO master.
// Assumes a 64-bit frame: 32 preamble ones followed by a 32-bit header and payload.
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_IDX     = 46;   // first turnaround bit in frame order
    localparam int DATA_IDX   = 48;   // first payload bit in frame order

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_RD22  = 2'd2,
        OP_RD45  = 2'd3
    } mdio_op_e;

    typedef struct packed {
        logic       go;
        logic       spare;
        logic [4:0] regad;
        logic [4:0] phy;
        logic [1:0] op;
        logic [1:0] st;
        logic [15:0] data;
    } mdio_cmd_t;

    localparam logic [1:0] TA_DRIVEN = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
// Module: MDC generator. It divides clk by 2*HALF_DIV while run is high and
// flags the system cycle just before each MDC edge.
// Assumes HALF_DIV >= 2. MDC is held low and the phase counter is cleared when run is low.
module mdio_clkgen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;
    logic          mdc_q;
    logic          wrap;

    // Phase wrap: MDC toggles at the next clock edge.
    always_comb begin
        wrap     = run && (cnt == LAST);
        rise_evt = wrap && !mdc_q;
        fall_evt = wrap && mdc_q;
    end

    // Phase counter and MDC toggle flop.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            mdc_q <= !mdc_q;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    assign mdc = mdc_q;

    AST_EVT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |=> mdc) else $error("rise event not followed by MDC high"); // R10
endmodule

// File: rtl/mdio_frame_engine.sv
// Module: frame serializer. It loads a 64-bit frame on start, shifts one bit per
// MDC falling edge, releases MDIO for read turnaround/data and captures read bits
// at rising edges.
// Assumes start arrives only while idle. rise_evt/fall_evt come from mdio_clkgen.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  st,
    input  logic [1:0]  op,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    input  logic [15:0] payload,
    input  logic        rise_evt,
    input  logic        fall_evt,
    input  logic        mdio_i,
    output logic        active,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic [15:0] rd_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_I     = IDX_W'(TA_IDX);
    localparam logic [IDX_W-1:0] DATA_I   = IDX_W'(DATA_IDX);

    logic [FRAME_BITS-1:0] shreg;
    logic [IDX_W-1:0]      idx;
    logic                  rd_q;
    logic                  active_q;
    logic [1:0]            ta_bits;

    // Turnaround pattern: driven for address/write, don't-care (released) for reads.
    always_comb ta_bits = op[1] ? 2'b00 : TA_DRIVEN;

    // Frame sequencing: load, advance on falling MDC, stop after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx      <= '0;
            shreg    <= '0;
            rd_q     <= 1'b0;
        end else if (start && !active_q) begin
            active_q <= 1'b1;
            idx      <= '0;
            rd_q     <= op[1];
            shreg    <= {{32{1'b1}}, st, op, phy, regad, ta_bits, payload};
        end else if (active_q && fall_evt) begin
            if (idx == LAST_IDX) begin
                active_q <= 1'b0;
            end else begin
                idx   <= idx + 1'b1;
                shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    // Read capture: shift in MDIO at each rising MDC during the payload bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (active_q && rd_q && rise_evt && idx >= DATA_I) begin
            rd_data <= {rd_data[14:0], mdio_i};
        end
    end

    // Output drive and completion strobe.
    always_comb begin
        active  = active_q;
        mdio_o  = active_q && shreg[FRAME_BITS-1];
        mdio_oe = active_q && !(rd_q && idx >= TA_I);
        done    = active_q && fall_evt && (idx == LAST_IDX);
    end

    AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && idx < IDX_W'(32)) |-> (mdio_oe && mdio_o)) else $error("preamble bit not one"); // R3
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !fall_evt) |=> $stable(mdio_o)) else $error("MDIO changed off a falling edge"); // R11
    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && rd_q && rise_evt && idx >= DATA_I) |-> !mdio_oe) else $error("driving during read data"); // R6
    AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !active_q) else $error("engine still active after done"); // R7
endmodule

// File: rtl/mdio_mgmt_master.sv
// Module: top of the MDIO management master. It holds the command register,
// starts a frame when go is written while idle, and merges read data and clears
// go on completion.
// Assumes the host polls bit 31 before issuing another command.
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_cmd_t   cmd_q;
    mdio_cmd_t   wr;
    logic        start;
    logic        run;
    logic        rise_evt;
    logic        fall_evt;
    logic        fr_done;
    logic [15:0] rd_data;

    // Decode the incoming word and qualify a start.
    always_comb begin
        wr    = mdio_cmd_t'(cmd_wdata);
        start = cmd_wr && !cmd_q.go && wr.go;
    end

    // Command register: accept writes only while idle; complete on frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (fr_done) begin
            cmd_q.go <= 1'b0;
            if (cmd_q.op[1]) cmd_q.data <= rd_data;
        end else if (cmd_wr && !cmd_q.go) begin
            cmd_q <= wr;
        end
    end

    assign cmd_rdata = cmd_q;

    mdio_clkgen #(.HALF_DIV(MDC_HALF_DIV)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .st       (wr.st),
        .op       (wr.op),
        .phy      (wr.phy),
        .regad    (wr.regad),
        .payload  (wr.data),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .active   (run),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (fr_done),
        .rd_data  (rd_data)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_q.go |-> (!mdc && !mdio_oe)) else $error("bus active while idle"); // R10
    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q.go && cmd_wr && !fr_done) |=> (cmd_q == $past(cmd_q))) else $error("write accepted while busy"); // R8
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fr_done |=> !cmd_q.go) else $error("busy not cleared"); // R7
    AST_BUSY_TRACKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cmd_q.go) else $error("frame running without busy"); // R7
endmodule

// File: tb/sim_mdio_mgmt_master.sv
// Bench: vector table of commands and PHY responses, then directed corner tests.
module sim_mdio_mgmt_master;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Frame observer state.
    int          rise_cnt = 0;
    logic [63:0] seen_o;
    logic [63:0] seen_oe;
    logic        last_o = 1'b0;
    int          stab_err = 0;
    logic [15:0] resp_q = '0;
    time         t_r1 = 0;
    time         t_r2 = 0;

    always #10 clk = ~clk;   // 50 MHz

    mdio_mgmt_master #(.MDC_HALF_DIV(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    // {command word, PHY response}
    localparam logic [47:0] VEC [6] = '{
        {32'h8815_A5C3, 16'h0000},   // short-form write
        {32'hBFE9_0000, 16'h3C96},   // short-form read
        {32'h8E50_8001, 16'h0000},   // long-form address
        {32'h8E54_1234, 16'h0000},   // long-form write
        {32'h8E5C_0000, 16'hF00F},   // long-form read
        {32'h8009_0000, 16'h8000}    // short-form read, MSB only
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Capture wire bits at each rising MDC; track output value half a clock before.
    initial forever begin
        @(negedge clk);
        last_o = mdio_o;
    end
    initial forever begin
        @(posedge mdc);
        #1;
        if (rise_cnt < 64) begin
            seen_o[rise_cnt]  = mdio_o;
            seen_oe[rise_cnt] = mdio_oe;
            if (mdio_oe && mdio_o != last_o) stab_err++;
            if (rise_cnt == 1) t_r1 = $time;
            if (rise_cnt == 2) t_r2 = $time;
        end
        rise_cnt++;
    end
    // PHY responder: present read data after falling MDC for bits 48..63.
    initial forever begin
        @(negedge mdc);
        if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = resp_q[63 - rise_cnt];
    end

    task automatic write_cmd(input logic [31:0] w);
        @(negedge clk);
        cmd_wr    = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_wr    = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (cmd_rdata[31] && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic run_frame(input logic [31:0] w, input logic [15:0] resp);
        logic [63:0] exp_f;
        logic        is_rd;
        logic [31:0] exp_reg;
        bit          ok_bits;
        bit          ok_oe;
        is_rd    = w[19];
        exp_f    = {32'hFFFF_FFFF, w[17:16], w[19:18], w[24:20], w[29:25],
                    is_rd ? 2'b00 : 2'b10, w[15:0]};
        exp_reg  = is_rd ? {1'b0, w[30:16], resp} : {1'b0, w[30:0]};
        rise_cnt = 0;
        stab_err = 0;
        resp_q   = resp;
        write_cmd(w);
        chk(cmd_rdata[31] == 1'b1, "R7 busy set after go", {63'd0, cmd_rdata[31]}, 64'd1);
        wait_idle();
        ok_bits = 1'b1;
        ok_oe   = 1'b1;
        for (int k = 0; k < 64; k++) begin
            if (!(is_rd && k >= 46) && seen_o[k] != exp_f[63-k]) ok_bits = 1'b0;
            if (seen_oe[k] != !(is_rd && k >= 46)) ok_oe = 1'b0;
        end
        chk(ok_bits && rise_cnt == 64, "R3 R4 R5 frame bits", seen_o, exp_f);
        chk(ok_oe, is_rd ? "R6 read release" : "R5 driven turnaround", seen_oe, 64'd0);
        chk(cmd_rdata == exp_reg, is_rd ? "R6 R7 read result" : "R7 word kept", {32'd0, cmd_rdata}, {32'd0, exp_reg});
        chk(stab_err == 0, "R11 stable at rising MDC", 64'(stab_err), 64'd0);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_rdata == 32'd0, "R1 register zero", {32'd0, cmd_rdata}, 64'd0);
        chk(!mdc && !mdio_oe, "R1 bus quiet", {62'd0, mdc, mdio_oe}, 64'd0);

        // R2..R7, R11: vector table
        for (int v = 0; v < 6; v++) run_frame(VEC[v][47:16], VEC[v][15:0]);

        // R10 MDC period and idle state
        chk((t_r2 - t_r1) == time'(2 * HALF * 20), "R10 MDC period", 64'(t_r2 - t_r1), 64'(2 * HALF * 20));
        repeat (5) @(negedge clk);
        chk(!mdc && !mdio_oe, "R10 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);

        // R9 no-go write: stored, no frame
        rise_cnt = 0;
        write_cmd(32'h0815_A5C3);
        repeat (40) @(negedge clk);
        chk(cmd_rdata == 32'h0815_A5C3, "R9 word stored", {32'd0, cmd_rdata}, 64'h0815_A5C3);
        chk(rise_cnt == 0 && !mdio_oe, "R9 no frame", 64'(rise_cnt), 64'd0);

        // R8 write while busy is ignored
        rise_cnt = 0;
        resp_q   = 16'h0000;
        write_cmd(32'h8815_5AA5);
        repeat (100) @(negedge clk);
        write_cmd(32'hBFE9_0000);
        chk(cmd_rdata == 32'h8815_5AA5, "R8 busy word unchanged", {32'd0, cmd_rdata}, 64'h8815_5AA5);
        wait_idle();
        chk(cmd_rdata == 32'h0815_5AA5 && rise_cnt == 64, "R8 original frame completes",
            {32'd0, cmd_rdata}, 64'h0815_5AA5);
        chk(seen_oe[47] == 1'b1 && seen_o[63] == 1'b1, "R8 frame still a write", {62'd0, seen_oe[47], seen_o[63]}, 64'd3);

        // R1 reset mid-frame returns to quiet state
        write_cmd(32'h8E54_00FF);
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_rdata == 32'd0 && !mdc && !mdio_oe, "R1 reset mid-frame", {32'd0, cmd_rdata}, 64'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule